// File: doc/BRIEF.md
# Serial Command Front End for a Digitally Set Resistor

This block is the serial control side of a programmable resistor. It watches a chip-select-framed serial bus (clock idles low; input data is taken on the falling clock edge and the output changes on the rising edge). All three bus lines are first brought into a faster system clock domain. Every 16-bit word received is decoded as a command. The block holds a 10-bit wiper position and a 4-bit control word, and it keeps wiper writes blocked until software unlocks them. It also holds a shutdown flag. Read results are returned during the next frame on a serial output, which is modelled as a data bit plus an active-low drive enable.

Nonvolatile store, restore and slot reads are not done here. They go to a separate memory controller through a request pulse, a busy level and a done pulse. When several devices are chained, a 32-bit frame passes the first word on to the downstream device, and only the final word is decoded locally. A resolution parameter produces a coarser variant in which the lowest wiper bits are forced to zero.

Top module: `rheo_spi_frontend`

## Requirements
- R1: A word is 16 bits sent MSB first: bits 15:14 are padding, bits 13:10 are the command, bits 9:0 are data. The command runs after chip select rises on a frame whose falling-clock count is a nonzero multiple of 16. Command codes: 0 no-op, 1 wiper write, 2 wiper read, 3 store, 4 restore, 5 slot read (slot in data[5:0]), 6 last-slot read, 7 control write, 8 control read, 9 shutdown. Codes 10 to 15 do nothing.
- R2: A frame whose clock count is not a multiple of 16 changes no state.
- R3: After reset the wiper is 0x200. Command 1 loads the wiper only while control bit 1 is 1. Otherwise the wiper keeps its value.
- R4: Command 7 loads control bits 2:0 from data[2:0], and all three clear at reset. Bit 3 cannot be written. The calibration-off output follows control bit 2.
- R5: Commands 2, 5, 6 and 8 put their result, zero-extended, in the 16-bit word shifted out during the next frame. A frame that follows any other command shifts out zeros.
- R6: The serial output bit changes only after a rising bus clock while chip select is low.
- R7: In a 32-bit frame, the output during clocks 17 to 32 repeats the first 16 input bits, and the last 16 bits are decoded.
- R8: Command 9 sets the shutdown flag from data[0]. Command 4 clears the flag. All commands still work while shutdown is set.
- R9: Command 3 sends a store request carrying the wiper value only while control bit 0 is 1. When the store completes, control bit 3 takes the controller's success flag.
- R10: Command 4 sends a restore request regardless of the protect bits. When it completes, the returned value becomes the wiper.
- R11: A frame that ends while the memory controller is busy, or while a request is still outstanding, is discarded.
- R12: The word 0x8001 followed by a no-op frame (0x0000) releases the output drive, so the drive enable stays high during frames. The next decoded word other than a no-op restores the drive.
- R13: With RES_BITS below 10, the lowest 10-RES_BITS wiper bits are forced to zero on write, restore and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bus clock |
| csn_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out bit |
| sdo_drv_n_o | output | 1 | Active-low drive enable for sdo_o |
| wiper_o | output | 10 | Wiper position |
| shutdown_o | output | 1 | Shutdown flag |
| cal_off_o | output | 1 | Tolerance calibration disabled |
| nv_req_o | output | 1 | One-cycle request to memory controller |
| nv_op_o | output | 2 | Request kind: 1 store, 2 restore, 3 slot read |
| nv_slot_o | output | 6 | Slot index for slot read |
| nv_wdata_o | output | 10 | Value to store |
| nv_busy_i | input | 1 | Memory controller busy |
| nv_done_i | input | 1 | Completion pulse |
| nv_ok_i | input | 1 | Store success, valid with done |
| nv_rdata_i | input | 10 | Restore or slot-read data, valid with done |
| nv_last_i | input | 6 | Address of last programmed slot |

## Verification
Frames of 15, 16, 17 and 32 clocks show whether the bit count gates the decode and whether the chained word is passed through rather than decoded. Wiper writes are sent with the protect bit both clear and set, and with a store still outstanding, to separate the three reasons a write can be ignored. Paired read and follow-up frames confirm that results appear one frame late and that a second frame returns zeros. A seeded random mix of writes, control changes, shutdown and reads is checked against a bench model, and a second instance at 8-bit resolution shows the masked low bits.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 10;
  localparam int CMD_W      = 4;
  localparam int SLOT_W     = 6;
  localparam int CTRL_W     = 4;
  localparam logic [FRAME_BITS-1:0] HIZ_KEY = 16'h8001;

  // Control word bit positions
  localparam int CB_PROG_EN  = 0;
  localparam int CB_WIPER_EN = 1;
  localparam int CB_CAL_OFF  = 2;
  localparam int CB_STORE_OK = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_WR_WIPER = 4'd1,
    CMD_RD_WIPER = 4'd2,
    CMD_STORE    = 4'd3,
    CMD_RESTORE  = 4'd4,
    CMD_RD_SLOT  = 4'd5,
    CMD_RD_LAST  = 4'd6,
    CMD_WR_CTRL  = 4'd7,
    CMD_RD_CTRL  = 4'd8,
    CMD_SHDN     = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    NV_NONE    = 2'd0,
    NV_STORE   = 2'd1,
    NV_RESTORE = 2'd2,
    NV_READ    = 2'd3
  } nv_op_e;

  typedef struct packed {
    logic [1:0]        pad;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Keeps the upper res_bits wiper bits, clears the rest
  function automatic logic [DATA_W-1:0] res_mask(input int res_bits);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= DATA_W - res_bits);
    return m;
  endfunction
endpackage

// File: rtl/rheo_spi_sync.sv
module rheo_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic din_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic din_s
);
  logic [STAGES-1:0] sclk_p, csn_p, din_p;
  logic sclk_d, csn_d;
  logic sclk_s, csn_s;

  assign sclk_s = sclk_p[STAGES-1];
  assign csn_s  = csn_p[STAGES-1];
  assign din_s  = din_p[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_p <= '0; csn_p <= '1; din_p <= '0;
        end else begin
          sclk_p <= sclk_in; csn_p <= csn_in; din_p <= din_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_p <= '0; csn_p <= '1; din_p <= '0;
        end else begin
          sclk_p <= {sclk_p[STAGES-2:0], sclk_in};
          csn_p  <= {csn_p[STAGES-2:0], csn_in};
          din_p  <= {din_p[STAGES-2:0], din_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_rise   = csn_s & ~csn_d;
  assign cs_low    = ~csn_s;
endmodule

// File: rtl/rheo_frame_shifter.sv
module rheo_frame_shifter
  import rheo_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_rise,
  input  logic                  sclk_fall,
  input  logic                  cs_fall,
  input  logic                  cs_rise,
  input  logic                  cs_low,
  input  logic                  din_s,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic [FRAME_BITS-1:0] word,
  output logic                  word_valid,
  output logic                  sdo_bit
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  seen_q;
  logic                  sdo_q;
  logic                  valid_q;
  logic                  shift_ev;
  logic                  drive_ev;

  assign shift_ev = cs_low & sclk_fall;
  assign drive_ev = cs_low & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (cs_fall) begin
      sr_q   <= load_word;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (shift_ev) begin
      sr_q   <= {sr_q[FRAME_BITS-2:0], din_s};
      cnt_q  <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (drive_ev) sdo_q <= sr_q[FRAME_BITS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= cs_rise & seen_q & (cnt_q == '0);
  end

  assign word       = sr_q;
  assign word_valid = valid_q;
  assign sdo_bit    = sdo_q;

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(drive_ev)); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(cnt_q == '0 && seen_q)); // R2
endmodule

// File: rtl/rheo_cmd_core.sv
module rheo_cmd_core
  import rheo_pkg::*;
#(
  parameter int RES_BITS = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_valid,
  input  logic                  frame_start,
  input  logic [FRAME_BITS-1:0] word,
  input  logic                  nv_busy_i,
  input  logic                  nv_done_i,
  input  logic                  nv_ok_i,
  input  logic [DATA_W-1:0]     nv_rdata_i,
  input  logic [SLOT_W-1:0]     nv_last_i,
  output logic [DATA_W-1:0]     wiper_o,
  output logic [CTRL_W-1:0]     ctrl_o,
  output logic                  shutdown_o,
  output logic                  hiz_o,
  output logic [FRAME_BITS-1:0] resp_o,
  output logic                  nv_req_o,
  output nv_op_e                nv_op_o,
  output logic [SLOT_W-1:0]     nv_slot_o,
  output logic [DATA_W-1:0]     nv_wdata_o
);
  localparam logic [DATA_W-1:0] MASK = res_mask(RES_BITS);
  localparam logic [DATA_W-1:0] MID  = (DATA_W'(1) << (DATA_W - 1)) & MASK;

  frame_t fr;
  cmd_e   cmd;
  assign fr  = frame_t'(word);
  assign cmd = cmd_e'(fr.cmd);

  logic [DATA_W-1:0]     wiper_q;
  logic [CTRL_W-1:0]     ctrl_q;
  logic                  sd_q;
  logic                  arm_q, hiz_q;
  logic [FRAME_BITS-1:0] resp_q;
  logic                  nv_req_q, nv_wait_q;
  nv_op_e                pend_op_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [DATA_W-1:0]     wdata_q;

  // Named events for the assertions
  logic lock, cmd_exec, special_word, is_nop;
  logic wr_wiper_ok, store_go, restore_go, slot_go, nv_go;
  logic nv_fin, restore_done, store_done, read_done;
  logic is_read;
  logic [FRAME_BITS-1:0] read_val;

  assign lock         = nv_busy_i | nv_wait_q;
  assign cmd_exec     = word_valid & ~lock;
  assign special_word = (word == HIZ_KEY);
  assign is_nop       = (cmd == CMD_NOP) & ~special_word;
  assign wr_wiper_ok  = cmd_exec & (cmd == CMD_WR_WIPER) & ctrl_q[CB_WIPER_EN];
  assign store_go     = cmd_exec & (cmd == CMD_STORE) & ctrl_q[CB_PROG_EN];
  assign restore_go   = cmd_exec & (cmd == CMD_RESTORE);
  assign slot_go      = cmd_exec & (cmd == CMD_RD_SLOT);
  assign nv_go        = store_go | restore_go | slot_go;
  assign nv_fin       = nv_done_i & nv_wait_q;
  assign restore_done = nv_fin & (pend_op_q == NV_RESTORE);
  assign store_done   = nv_fin & (pend_op_q == NV_STORE);
  assign read_done    = nv_fin & (pend_op_q == NV_READ);

  always_comb begin
    is_read  = 1'b1;
    read_val = '0;
    case (cmd)
      CMD_RD_WIPER: read_val = FRAME_BITS'(wiper_q);
      CMD_RD_LAST:  read_val = FRAME_BITS'(nv_last_i);
      CMD_RD_CTRL:  read_val = FRAME_BITS'(ctrl_q);
      default:      is_read  = 1'b0;
    endcase
  end

  // Wiper position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wiper_q <= MID;
    else if (restore_done) wiper_q <= nv_rdata_i & MASK;
    else if (wr_wiper_ok)  wiper_q <= fr.data & MASK;
  end

  // Control word: bits 2:0 written by command, bit 3 by store result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else begin
      if (cmd_exec && cmd == CMD_WR_CTRL) ctrl_q[CB_CAL_OFF:CB_PROG_EN] <= fr.data[2:0];
      if (store_done) ctrl_q[CB_STORE_OK] <= nv_ok_i;
    end
  end

  // Shutdown flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else if (cmd_exec && cmd == CMD_SHDN) sd_q <= fr.data[0];
    else if (restore_go) sd_q <= 1'b0;
  end

  // Output release sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      hiz_q <= 1'b0;
    end else if (cmd_exec) begin
      arm_q <= special_word;
      if (arm_q && is_nop)                hiz_q <= 1'b1;
      else if (!is_nop && !special_word)  hiz_q <= 1'b0;
    end
  end

  // Deferred read response, consumed by the next frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   resp_q <= '0;
    else if (read_done)           resp_q <= FRAME_BITS'(nv_rdata_i & MASK);
    else if (cmd_exec && is_read) resp_q <= read_val;
    else if (frame_start)         resp_q <= '0;
  end

  // Memory controller handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_req_q  <= 1'b0;
      nv_wait_q <= 1'b0;
      pend_op_q <= NV_NONE;
      slot_q    <= '0;
      wdata_q   <= '0;
    end else begin
      nv_req_q <= nv_go;
      if (nv_go) begin
        nv_wait_q <= 1'b1;
        pend_op_q <= store_go ? NV_STORE : (restore_go ? NV_RESTORE : NV_READ);
        slot_q    <= fr.data[SLOT_W-1:0];
        wdata_q   <= wiper_q;
      end else if (nv_fin) begin
        nv_wait_q <= 1'b0;
      end
    end
  end

  assign wiper_o    = wiper_q;
  assign ctrl_o     = ctrl_q;
  assign shutdown_o = sd_q;
  assign hiz_o      = hiz_q;
  assign resp_o     = resp_q;
  assign nv_req_o   = nv_req_q;
  assign nv_op_o    = pend_op_q;
  assign nv_slot_o  = slot_q;
  assign nv_wdata_o = wdata_q;

  AST_WIPER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_q) |-> $past(wr_wiper_ok || restore_done)); // R3
  AST_STORE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req_q && pend_op_q == NV_STORE) |-> ctrl_q[CB_PROG_EN]); // R9
  AST_LOCK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy_i |=> !nv_req_q); // R11
  AST_SHDN_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_q) |-> $past(cmd_exec)); // R8
  AST_OK_BIT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q[CB_STORE_OK]) |-> $past(nv_fin)); // R4
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_q & ~MASK) == '0); // R13
endmodule

// File: rtl/rheo_spi_frontend.sv
module rheo_spi_frontend
  import rheo_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        csn_i,
  input  logic        din_i,
  output logic        sdo_o,
  output logic        sdo_drv_n_o,
  output logic [9:0]  wiper_o,
  output logic        shutdown_o,
  output logic        cal_off_o,
  output logic        nv_req_o,
  output logic [1:0]  nv_op_o,
  output logic [5:0]  nv_slot_o,
  output logic [9:0]  nv_wdata_o,
  input  logic        nv_busy_i,
  input  logic        nv_done_i,
  input  logic        nv_ok_i,
  input  logic [9:0]  nv_rdata_i,
  input  logic [5:0]  nv_last_i
);
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, din_s;
  logic [FRAME_BITS-1:0] word, resp;
  logic word_valid, sdo_bit, hiz;
  logic [CTRL_W-1:0] ctrl;
  nv_op_e nv_op;

  rheo_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_i), .csn_in(csn_i), .din_in(din_i),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_low(cs_low), .din_s(din_s)
  );

  rheo_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_low(cs_low), .din_s(din_s),
    .load_word(resp), .word(word), .word_valid(word_valid), .sdo_bit(sdo_bit)
  );

  rheo_cmd_core #(.RES_BITS(RES_BITS)) u_core (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .frame_start(cs_fall),
    .word(word), .nv_busy_i(nv_busy_i), .nv_done_i(nv_done_i), .nv_ok_i(nv_ok_i),
    .nv_rdata_i(nv_rdata_i), .nv_last_i(nv_last_i), .wiper_o(wiper_o),
    .ctrl_o(ctrl), .shutdown_o(shutdown_o), .hiz_o(hiz), .resp_o(resp),
    .nv_req_o(nv_req_o), .nv_op_o(nv_op), .nv_slot_o(nv_slot_o),
    .nv_wdata_o(nv_wdata_o)
  );

  assign sdo_o       = sdo_bit;
  assign sdo_drv_n_o = ~(cs_low & ~hiz);
  assign cal_off_o   = ctrl[CB_CAL_OFF];
  assign nv_op_o     = nv_op;

  AST_RELEASE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |-> sdo_drv_n_o); // R12
endmodule

// File: tb/rheo_spi_frontend_bench.sv
`timescale 1ns/1ps
module rheo_spi_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, din = 1'b0;
  logic sdo, drv_n, sd, cal_off, req;
  logic [9:0] wiper, wdata;
  logic [1:0] op;
  logic [5:0] slot;
  logic sdo8, drv8_n, sd8, cal8, req8;
  logic [9:0] wiper8, wdata8;
  logic [1:0] op8;
  logic [5:0] slot8;
  logic nv_busy = 1'b0, nv_done = 1'b0, nv_ok = 1'b0;
  logic [9:0] nv_rdata = '0;
  logic [5:0] nv_slots = '0;

  int errors = 0, checks = 0;
  int nv_lat = 20, nv_reqs = 0;
  logic nv_ok_cfg = 1'b1;
  logic [9:0] nv_mem = 10'h200;

  logic [9:0] exp_w = 10'h200;
  logic [3:0] exp_ctrl = 4'h0;
  logic exp_sd = 1'b0;
  logic [31:0] rx;
  logic seen_drive;

  always #2 clk = ~clk;

  rheo_spi_frontend u_rheo_spi_frontend (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .din_i(din),
    .sdo_o(sdo), .sdo_drv_n_o(drv_n), .wiper_o(wiper), .shutdown_o(sd),
    .cal_off_o(cal_off), .nv_req_o(req), .nv_op_o(op), .nv_slot_o(slot),
    .nv_wdata_o(wdata), .nv_busy_i(nv_busy), .nv_done_i(nv_done), .nv_ok_i(nv_ok),
    .nv_rdata_i(nv_rdata), .nv_last_i(nv_slots)
  );

  rheo_spi_frontend #(.RES_BITS(8)) u_rheo_spi_frontend_r8 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .din_i(din),
    .sdo_o(sdo8), .sdo_drv_n_o(drv8_n), .wiper_o(wiper8), .shutdown_o(sd8),
    .cal_off_o(cal8), .nv_req_o(req8), .nv_op_o(op8), .nv_slot_o(slot8),
    .nv_wdata_o(wdata8), .nv_busy_i(nv_busy), .nv_done_i(nv_done), .nv_ok_i(nv_ok),
    .nv_rdata_i(nv_rdata), .nv_last_i(nv_slots)
  );

  function automatic logic [15:0] mk(input logic [3:0] c, input logic [9:0] d);
    return {2'b00, c, d};
  endfunction

  function automatic logic [9:0] slot_pattern(input logic [5:0] s);
    return 10'((s * 37 + 5) & 10'h3FF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Sends nbits of tx, MSB first; collects output bits before each falling edge
  task automatic frame(input int nbits, input logic [31:0] tx);
    rx = '0;
    seen_drive = 1'b0;
    @(negedge clk); csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b1; din = tx[i];
      repeat (8) @(negedge clk);
      rx = {rx[30:0], sdo};
      if (!drv_n) seen_drive = 1'b1;
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] c, input logic [9:0] d);
    frame(16, {16'h0, mk(c, d)});
  endtask

  // Memory controller model
  initial begin
    forever begin
      @(negedge clk);
      if (req) begin
        nv_reqs++;
        nv_busy = 1'b1;
        repeat (nv_lat) @(negedge clk);
        case (op)
          2'd1: begin
            if (nv_ok_cfg) begin nv_mem = wdata; nv_slots = nv_slots + 1'b1; end
            nv_rdata = '0;
          end
          2'd2: nv_rdata = nv_mem;
          default: nv_rdata = slot_pattern(slot);
        endcase
        nv_ok = nv_ok_cfg;
        nv_busy = 1'b0; nv_done = 1'b1;
        @(negedge clk);
        nv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R3 reset wiper", wiper, 10'h200);
    chk("R4 reset cal_off", cal_off, 0);
    chk("R8 reset shutdown", sd, 0);
    chk("R12 reset drive_n", drv_n, 1);
    chk("R9 reset req", req, 0);

    send(4'd1, 10'h155);
    chk("R3 write while protected", wiper, exp_w);

    send(4'd7, 10'h00F); exp_ctrl = 4'h7;
    chk("R4 cal_off set", cal_off, 1);
    send(4'd8, 0); send(4'd0, 0);
    chk("R4 ctrl read bit3 read-only", rx[15:0], 16'h0007);
    send(4'd7, 10'h002); exp_ctrl = 4'h2;
    chk("R4 cal_off clear", cal_off, 0);

    send(4'd1, 10'h155); exp_w = 10'h155;
    chk("R3 write unlocked", wiper, exp_w);
    chk("R13 coarse wiper", wiper8, 10'h154);

    frame(15, {17'h0, mk(4'd1, 10'h0AA)} >> 1);
    chk("R2 15-bit frame ignored", wiper, exp_w);
    frame(17, {16'h0, 1'b0, mk(4'd1, 10'h0AA)});
    chk("R2 17-bit frame ignored", wiper, exp_w);

    frame(32, {mk(4'd1, 10'h033), mk(4'd1, 10'h0F0)}); exp_w = 10'h0F0;
    chk("R1 R7 chained frame decodes last word", wiper, exp_w);
    chk("R7 pass-through of first word", rx[15:0], mk(4'd1, 10'h033));

    send(4'd2, 0); send(4'd0, 0);
    chk("R5 wiper readback", rx[15:0], 16'h00F0);
    send(4'd0, 0);
    chk("R5 zeros after non-read", rx[15:0], 16'h0000);

    send(4'd9, 10'h001); exp_sd = 1;
    chk("R8 shutdown set", sd, 1);
    send(4'd1, 10'h123); exp_w = 10'h123;
    chk("R8 write in shutdown", wiper, exp_w);
    send(4'd9, 10'h000);
    chk("R8 shutdown clear", sd, 0);
    send(4'd9, 10'h001);

    base = nv_reqs;
    send(4'd3, 0); repeat (60) @(negedge clk);
    chk("R9 store blocked", nv_reqs, base);
    send(4'd7, 10'h003); exp_ctrl = 4'h3;
    send(4'd3, 0); repeat (60) @(negedge clk); exp_ctrl[3] = 1'b1;
    chk("R9 store requested", nv_reqs, base + 1);
    send(4'd8, 0); send(4'd0, 0);
    chk("R9 success bit set", rx[15:0], {12'h0, exp_ctrl});

    send(4'd1, 10'h2AA); exp_w = 10'h2AA;
    nv_ok_cfg = 1'b0;
    send(4'd3, 0); repeat (60) @(negedge clk); exp_ctrl[3] = 1'b0;
    send(4'd8, 0); send(4'd0, 0);
    chk("R9 failure clears bit", rx[15:0], {12'h0, exp_ctrl});
    nv_ok_cfg = 1'b1;

    send(4'd7, 10'h000); exp_ctrl[2:0] = 3'h0;
    send(4'd1, 10'h3FF);
    chk("R3 relocked", wiper, exp_w);
    send(4'd4, 0); repeat (60) @(negedge clk); exp_w = 10'h123; exp_sd = 0;
    chk("R10 restore while protected", wiper, exp_w);
    chk("R8 restore clears shutdown", sd, 0);
    chk("R13 coarse restore", wiper8, 10'h120);

    send(4'd7, 10'h003); exp_ctrl[2:0] = 3'h3;
    nv_lat = 600;
    send(4'd3, 0);
    send(4'd1, 10'h3FF);
    repeat (700) @(negedge clk);
    nv_lat = 20; exp_ctrl[3] = 1'b1;
    chk("R11 write during busy dropped", wiper, exp_w);

    send(4'd5, 10'h009); repeat (60) @(negedge clk);
    send(4'd0, 0);
    chk("R5 slot read", rx[15:0], {6'h0, slot_pattern(6'd9)});
    send(4'd6, 0); send(4'd0, 0);
    chk("R5 last slot read", rx[15:0], {10'h0, nv_slots});

    frame(16, 32'h8001); frame(16, 32'h0000);
    send(4'd8, 0);
    chk("R12 output released", seen_drive, 0);
    send(4'd0, 0);
    chk("R12 drive restored", seen_drive, 1);
    chk("R5 read during release", rx[15:0], {12'h0, exp_ctrl});

    for (int k = 0; k < 40; k++) begin
      logic [3:0] c;
      logic [9:0] d;
      int pick = $urandom_range(0, 4);
      d = 10'($urandom);
      case (pick)
        0, 1: c = 4'd1;
        2: c = 4'd7;
        3: c = 4'd9;
        default: c = 4'd0;
      endcase
      send(c, d);
      if (c == 4'd1 && exp_ctrl[1]) exp_w = d;
      if (c == 4'd7) exp_ctrl[2:0] = d[2:0];
      if (c == 4'd9) exp_sd = d[0];
      chk("R3 random wiper", wiper, exp_w);
      chk("R13 random coarse wiper", wiper8, exp_w & 10'h3FC);
      chk("R8 random shutdown", sd, exp_sd);
      chk("R4 random cal_off", cal_off, exp_ctrl[2]);
      if (k % 4 == 0) begin
        send(4'd2, 0); send(4'd0, 0);
        chk("R5 random wiper read", rx[15:0], {6'h0, exp_w});
      end
    end

    finish_run();
  end
endmodule